// File: doc/BRIEF.md
# Locked-Page Program Write Buffer

This block gathers the data words of one program operation before they are sent to a non-volatile array. It holds one page buffer for each array block. Each page is 16 words of 32 bits, which makes 64 bytes. A write is accepted only if its block is taking part in the operation. A block takes part when its bit is set both in the block-select mask and in the array-configuration mask.

The first accepted write latches the page offset from its address, and the buffer is then locked to that offset. Every later write goes to the same page in whatever block it names, so the offset bits of later addresses are ignored. All buffers share the one latched offset.

If a word is written more than once, only the most recent value is kept. A write to a block that is not taking part is discarded and raises a sticky drop flag. A single-cycle unlock pulse clears the lock, the offset, every word-valid bit and the drop flag. The next accepted write then starts a fresh page.

The programming path reads the buffers through a combinational port that takes a block index and a word index.

Top module: `prog_page_buf`

## Requirements
- R1: After reset, `locked` is 0, `page_off` is 0, `blk_loaded` is all zero and `drop_flag` is 0.
- R2: Address fields: bits [5:2] give the word index, bits [12:6] the page offset and bits [15:13] the block index. Bits [1:0] are ignored, and every write stores the full 32-bit word.
- R3: When not locked, the first accepted write sets `locked` and loads `page_off` with its address bits [12:6]. Both are visible one cycle after the write.
- R4: While locked, `page_off` keeps its value whatever offset later writes present. Those writes land in the locked page of the block they name.
- R5: Data written to block b, word w can be read on `rd_data` with `rd_valid`=1 from the cycle after the write, by setting `rd_blk`=b and `rd_word`=w.
- R6: A later write to the same block and word replaces the earlier data.
- R7: Block b takes part only when `blk_sel[b]` and `cfg_map[b]` are both 1. A write to a block that does not take part changes no buffer, does not lock, and sets `drop_flag` from the next cycle. The flag stays set until unlock.
- R8: `blk_loaded[b]` is 1 exactly when at least one word of block b is valid, and `rd_valid` shows the valid bit of the word being read.
- R9: An unlock pulse clears `locked`, `page_off`, all valid bits and `drop_flag` in the next cycle. A write in the same cycle as the unlock is discarded.
- R10: After an unlock, the next accepted write captures a new page offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 16 | Write byte address |
| wr_data | input | 32 | Write data word |
| blk_sel | input | 8 | Block-select mask for this operation |
| cfg_map | input | 8 | Array configuration mask of usable blocks |
| unlock | input | 1 | Clears the lock, the offset, the valid bits and the drop flag |
| rd_blk | input | 3 | Read block index |
| rd_word | input | 4 | Read word index |
| rd_data | output | 32 | Stored word at rd_blk/rd_word |
| rd_valid | output | 1 | Word at rd_blk/rd_word has been written |
| blk_loaded | output | 8 | Per-block flag: at least one word is valid |
| locked | output | 1 | A page offset is latched |
| page_off | output | 7 | Latched page offset |
| drop_flag | output | 1 | Sticky: a write to a block not taking part was discarded |

## Verification
The bench goes after a second write that presents a different offset. A design that relatched the offset would move `page_off` and break R4.

It sends dropped writes while unlocked. A design that let a dropped write take the lock would show `locked` too early and would capture the wrong page.

It issues an unlock in the same cycle as a write. If the write won, a word would stay valid after the clear.

It also rewrites the same word and uses nonzero low address bits. These catch a buffer that keeps the first value instead of the last, and a decoder that takes the word index from the wrong bits.

// File: rtl/pb_pkg.sv
package pb_pkg;
  // Fixed address layout: two byte-lane bits below the word index.
  localparam int unsigned WORD_LSB = 2;

  typedef enum logic [1:0] {
    WR_IDLE   = 2'd0,
    WR_ACCEPT = 2'd1,
    WR_DROP   = 2'd2,
    WR_CLEAR  = 2'd3
  } wr_kind_e;
endpackage

// File: rtl/pb_addr_lock.sv
module pb_addr_lock #(
  parameter int unsigned OFFW = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            capture,
  input  logic [OFFW-1:0] off_in,
  output logic            locked,
  output logic [OFFW-1:0] off_q
);
  logic            locked_d;
  logic [OFFW-1:0] off_d;
  logic            upd;

  always_comb begin
    locked_d = locked;
    off_d    = off_q;
    upd      = 1'b0;
    if (clear) begin
      locked_d = 1'b0;
      off_d    = '0;
      upd      = 1'b1;
    end else if (capture && !locked) begin
      locked_d = 1'b1;
      off_d    = off_in;
      upd      = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked <= 1'b0;
      off_q  <= '0;
    end else if (upd) begin
      locked <= locked_d;
      off_q  <= off_d;
    end
  end

  // R4: once latched, the offset only moves through a clear
  a_r4_offset_held: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !clear) |=> (locked && $stable(off_q)));

  // R3: first capture latches the presented offset
  a_r3_first_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && capture && !clear) |=> (locked && off_q == $past(off_in)));
endmodule

// File: rtl/pb_word_bank.sv
module pb_word_bank #(
  parameter int unsigned DW    = 32,
  parameter int unsigned NWORD = 16,
  localparam int unsigned WIDX = $clog2(NWORD)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            we,
  input  logic [WIDX-1:0] widx,
  input  logic [DW-1:0]   wdata,
  input  logic [WIDX-1:0] ridx,
  output logic [DW-1:0]   rdata,
  output logic            rvalid,
  output logic            loaded
);
  logic [DW-1:0]    mem_q [NWORD];
  logic [NWORD-1:0] val_q;
  logic [NWORD-1:0] val_d;

  always_comb begin
    val_d = val_q;
    if (clear)   val_d = '0;
    else if (we) val_d[widx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val_q <= '0;
    else        val_q <= val_d;
  end

  // Data storage carries no reset; validity is tracked by val_q.
  always_ff @(posedge clk) begin
    if (we && !clear) mem_q[widx] <= wdata;
  end

  assign rdata  = mem_q[ridx];
  assign rvalid = val_q[ridx];
  assign loaded = |val_q;

  // R6: the written word reads back its newest value
  a_r6_last_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !clear) |=> (mem_q[$past(widx)] == $past(wdata) && val_q[$past(widx)]));

  // R9: clear empties the bank
  a_r9_bank_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !loaded);
endmodule

// File: rtl/prog_page_buf.sv
module prog_page_buf #(
  parameter int unsigned DW    = 32,
  parameter int unsigned NBLK  = 8,
  parameter int unsigned NWORD = 16,
  parameter int unsigned OFFW  = 7,
  localparam int unsigned WIDX    = $clog2(NWORD),
  localparam int unsigned BIDX    = $clog2(NBLK),
  localparam int unsigned OFF_LSB = pb_pkg::WORD_LSB + WIDX,
  localparam int unsigned BLK_LSB = OFF_LSB + OFFW,
  localparam int unsigned AW      = BLK_LSB + BIDX
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic [NBLK-1:0] blk_sel,
  input  logic [NBLK-1:0] cfg_map,
  input  logic            unlock,
  input  logic [BIDX-1:0] rd_blk,
  input  logic [WIDX-1:0] rd_word,
  output logic [DW-1:0]   rd_data,
  output logic            rd_valid,
  output logic [NBLK-1:0] blk_loaded,
  output logic            locked,
  output logic [OFFW-1:0] page_off,
  output logic            drop_flag
);
  import pb_pkg::*;

  wr_kind_e        kind;
  logic [BIDX-1:0] w_blk;
  logic [WIDX-1:0] w_word;
  logic [OFFW-1:0] w_off;
  logic [NBLK-1:0] part;
  logic            drop_d;

  assign w_blk  = wr_addr[BLK_LSB +: BIDX];
  assign w_word = wr_addr[WORD_LSB +: WIDX];
  assign w_off  = wr_addr[OFF_LSB +: OFFW];
  assign part   = blk_sel & cfg_map;

  always_comb begin
    if (unlock)             kind = WR_CLEAR;
    else if (!wr_en)        kind = WR_IDLE;
    else if (part[w_blk])   kind = WR_ACCEPT;
    else                    kind = WR_DROP;
  end

  pb_addr_lock #(.OFFW(OFFW)) u_lock (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (kind == WR_CLEAR),
    .capture (kind == WR_ACCEPT),
    .off_in  (w_off),
    .locked  (locked),
    .off_q   (page_off)
  );

  logic [DW-1:0] bank_rdata [NBLK];
  logic [NBLK-1:0] bank_rvalid;

  for (genvar b = 0; b < NBLK; b++) begin : g_bank
    pb_word_bank #(.DW(DW), .NWORD(NWORD)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (kind == WR_CLEAR),
      .we     (kind == WR_ACCEPT && w_blk == BIDX'(b)),
      .widx   (w_word),
      .wdata  (wr_data),
      .ridx   (rd_word),
      .rdata  (bank_rdata[b]),
      .rvalid (bank_rvalid[b]),
      .loaded (blk_loaded[b])
    );
  end

  assign rd_data  = bank_rdata[rd_blk];
  assign rd_valid = bank_rvalid[rd_blk];

  always_comb begin
    drop_d = drop_flag;
    if (kind == WR_CLEAR)     drop_d = 1'b0;
    else if (kind == WR_DROP) drop_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drop_flag <= 1'b0;
    else        drop_flag <= drop_d;
  end

  // R7: a discarded write leaves buffers and lock alone, raises the flag
  a_r7_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !unlock && !(blk_sel[w_blk] && cfg_map[w_blk]))
      |=> (drop_flag && $stable(blk_loaded) && $stable(locked)));

  // R9: unlock clears everything visible
  a_r9_unlock: assert property (@(posedge clk) disable iff (!rst_n)
    unlock |=> (!locked && page_off == '0 && blk_loaded == '0 && !drop_flag));

  // R8: an accepted write marks its block loaded
  a_r8_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !unlock && blk_sel[w_blk] && cfg_map[w_blk]) |=> blk_loaded[$past(w_blk)]);
endmodule

// File: tb/prog_page_buf_bench.sv
`timescale 1ns/1ps
module prog_page_buf_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [15:0] wr_addr;
  logic [31:0] wr_data;
  logic [7:0]  blk_sel, cfg_map;
  logic        unlock;
  logic [2:0]  rd_blk;
  logic [3:0]  rd_word;
  logic [31:0] rd_data;
  logic        rd_valid;
  logic [7:0]  blk_loaded;
  logic        locked;
  logic [6:0]  page_off;
  logic        drop_flag;

  prog_page_buf u_prog_page_buf (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .blk_sel(blk_sel), .cfg_map(cfg_map), .unlock(unlock), .rd_blk(rd_blk),
    .rd_word(rd_word), .rd_data(rd_data), .rd_valid(rd_valid),
    .blk_loaded(blk_loaded), .locked(locked), .page_off(page_off), .drop_flag(drop_flag)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [31:0] m_data [8][16];
  logic        m_val  [8][16];
  logic        m_lock;
  logic [6:0]  m_off;
  logic        m_drop;

  function automatic logic [15:0] mk_addr(int blk, int off, int word, int lane);
    return 16'((blk << 13) | (off << 6) | (word << 2) | lane);
  endfunction

  function automatic logic [7:0] exp_loaded();
    logic [7:0] r = '0;
    for (int b = 0; b < 8; b++)
      for (int w = 0; w < 16; w++)
        if (m_val[b][w]) r[b] = 1'b1;
    return r;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model_step(logic en, logic [15:0] a, logic [31:0] d, logic ul);
    int b = int'(a[15:13]);
    int w = int'(a[5:2]);
    if (ul) begin
      m_lock = 0; m_off = '0; m_drop = 0;
      for (int i = 0; i < 8; i++) for (int j = 0; j < 16; j++) m_val[i][j] = 0;
    end else if (en) begin
      if (blk_sel[b] && cfg_map[b]) begin
        m_data[b][w] = d;
        m_val[b][w]  = 1;
        if (!m_lock) begin m_lock = 1; m_off = a[12:6]; end
      end else m_drop = 1;
    end
  endtask

  // Drive at negedge, model update, compare at the following negedge.
  task automatic op(logic en, logic [15:0] a, logic [31:0] d, logic ul);
    @(negedge clk);
    wr_en = en; wr_addr = a; wr_data = d; unlock = ul;
    model_step(en, a, d, ul);
    @(negedge clk);
    wr_en = 0; unlock = 0;
  endtask

  task automatic check_state(string tag);
    chk({tag, " locked"},  32'(locked),     32'(m_lock));
    chk({tag, " off"},     32'(page_off),   32'(m_off));
    chk({tag, " drop"},    32'(drop_flag),  32'(m_drop));
    chk({tag, " loaded"},  32'(blk_loaded), 32'(exp_loaded()));
  endtask

  task automatic check_word(string tag, int b, int w);
    rd_blk = 3'(b); rd_word = 4'(w);
    #1;
    chk({tag, " rvalid"}, 32'(rd_valid), 32'(m_val[b][w]));
    if (m_val[b][w]) chk({tag, " rdata"}, rd_data, m_data[b][w]);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 0; wr_en = 0; wr_addr = '0; wr_data = '0; unlock = 0;
    blk_sel = 8'h0F; cfg_map = 8'hFF; rd_blk = '0; rd_word = '0;
    m_lock = 0; m_off = '0; m_drop = 0;
    for (int i = 0; i < 8; i++) for (int j = 0; j < 16; j++) begin
      m_val[i][j] = 0; m_data[i][j] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_state("R1 reset");

    // R7: dropped write while unlocked must not take the lock
    op(1, mk_addr(5, 33, 2, 0), 32'hDEAD_0001, 0);
    check_state("R7 drop unlocked");
    check_word("R7 no write", 5, 2);

    // R3: first accepted write latches offset 21
    op(1, mk_addr(1, 21, 3, 0), 32'h1111_0003, 0);
    check_state("R3 capture");
    check_word("R5 readback", 1, 3);

    // R4: different offset presented, same page used
    op(1, mk_addr(2, 99, 7, 0), 32'h2222_0007, 0);
    check_state("R4 hold");
    check_word("R4 redirected", 2, 7);

    // R6: overwrite same word
    op(1, mk_addr(1, 5, 3, 0), 32'h3333_AAAA, 0);
    check_word("R6 last wins", 1, 3);

    // R2: byte-lane bits ignored
    op(1, mk_addr(0, 21, 15, 3), 32'h4444_000F, 0);
    check_word("R2 lane ignored", 0, 15);
    check_word("R2 neighbour", 0, 14);

    // R9: unlock with simultaneous write
    op(1, mk_addr(3, 21, 0, 0), 32'h5555_0000, 1);
    check_state("R9 unlock");
    check_word("R9 cleared", 3, 0);
    check_word("R8 cleared", 1, 3);

    // R10: new offset after unlock
    op(1, mk_addr(3, 77, 9, 0), 32'h6666_0009, 0);
    check_state("R10 new offset");
    check_word("R8 valid", 3, 9);

    // Random phase: R4 R5 R6 R7 R8 R9
    for (int n = 0; n < 600; n++) begin
      logic ul = ($urandom % 24) == 0;
      logic en = ($urandom % 5) != 0;
      if (ul) begin
        blk_sel = 8'($urandom); cfg_map = 8'($urandom) | 8'h81;
      end
      op(en, mk_addr(int'($urandom % 8), int'($urandom % 128), int'($urandom % 16),
                     int'($urandom % 4)), $urandom, ul);
      check_state("R8 random");
      check_word("R5 random", int'($urandom % 8), int'($urandom % 16));
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule